// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers a set of level-sensitive peripheral request lines and a small group of software-owned request bits. It gives every source a programmable 4-bit priority and continuously picks the most urgent pending source. The winner is offered to the processor as a registered interrupt line together with a 9-bit vector. Each source's vector is simply its index. Sources 0 to NUM_SW-1 are the software bits. Sources NUM_SW and above map to peripheral line `hw_req_i[j]` as index NUM_SW+j.

Software uses a small word-addressed register bus with one access per cycle. It programs priorities and sets or clears the software bits. It can also raise a ceiling value, which holds back every source that is not strictly more urgent than that value. This lets tasks that share a resource run without preempting one another. Reading the acknowledge address claims the current winner. The old ceiling is saved on an internal stack, and the winner's priority becomes the new ceiling. A write to the end-of-service address restores the saved ceiling.

Register offsets: 0x00 ceiling (read/write, bits 3:0), 0x01 acknowledge (read), 0x02 end-of-service (write, data ignored), 0x03 software set (write sets the bits given as ones; read returns the software bits), 0x04 software clear (write clears the bits given as ones), and 0x40+i priority of source i (read/write, bits 3:0). Read data is returned one clock after the request, with `bus_rvalid_o` high. Unmapped addresses read as zero.

Top module: `pic_ctrl`

## Requirements
- R1: After a synchronous reset, `irq_o` is low, and the ceiling, the software bits and every priority read back as 0.
- R2: The vector of source i is i in bits 8:0. Software bit k is source k, and peripheral line j is source NUM_SW+j. `irq_vec_o` shows the vector of the source behind `irq_o`.
- R3: A write to 0x03 sets each software bit whose data bit is 1, and a write to 0x04 clears each such bit. A read of 0x03 returns the software bits.
- R4: A source whose priority is 0 never raises `irq_o`, even when pending.
- R5: Among eligible pending sources, the one with the numerically highest priority wins.
- R6: Among eligible pending sources of equal priority, the lowest index wins.
- R7: A pending source is eligible only if its priority is strictly greater than the ceiling. A write to 0x00 sets the ceiling.
- R8: A read of 0x01 while `irq_o` is high returns the presented vector. It pushes the old ceiling onto a stack of at least 16 entries and loads the winner's priority as the new ceiling.
- R9: A write to 0x02 pops the stack into the ceiling. With an empty stack, the ceiling becomes 0.
- R10: A read of 0x01 while `irq_o` is low returns 0x1FF and leaves the ceiling and the stack unchanged.
- R11: `irq_o` is registered. It reflects a change to the pending sources, the priorities or the ceiling at the first rising clock edge after that change.
- R12: Peripheral lines are level-sensitive. A source stays pending while its line is high, even across an acknowledge, and stops being pending once the line drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| hw_req_i | input | NUM_HW | Level-sensitive peripheral request lines |
| bus_valid_i | input | 1 | Register access strobe, one access per cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid one clock after the read |
| bus_rvalid_o | output | 1 | Read data valid |
| irq_o | output | 1 | Registered interrupt request to the processor |
| irq_vec_o | output | 9 | Vector of the presented source |

## Verification
An acknowledge read and a change in the winning source can land on the same clock edge. The acknowledge uses the registered winner, while the arbiter register is reloading from the new request state at that same edge. The bench drops the winning peripheral line in the very cycle of the acknowledge read. It then expects three things: the read returns the vector that `irq_o` had been advertising, the ceiling takes that source's priority, and `irq_o` is low right after the edge. A following end-of-service must return the ceiling to 0.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int VEC_W  = 9;
    localparam int PRIO_W = 4;

    localparam int ADR_CEIL      = 'h00;
    localparam int ADR_ACK       = 'h01;
    localparam int ADR_EOS       = 'h02;
    localparam int ADR_SWSET     = 'h03;
    localparam int ADR_SWCLR     = 'h04;
    localparam int ADR_PRIO_BASE = 'h40;

    localparam logic [VEC_W-1:0] SPURIOUS_VEC = '1;

    typedef logic [PRIO_W-1:0] prio_t;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] vec;
        prio_t            prio;
    } winner_t;

    typedef enum logic [1:0] {
        CEIL_HOLD,
        CEIL_LOAD,
        CEIL_PUSH,
        CEIL_POP
    } ceil_op_e;

    function automatic logic addr_hit(input logic [15:0] addr, input int offset);
        return addr == 16'(offset);
    endfunction
endpackage

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
    import pic_pkg::*;
#(
    parameter int NUM_SW  = 8,
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NUM_SW-1:0] sw_data_i,
    input  prio_t             prio_data_i,
    output logic [NUM_SW-1:0] sw_bits_o,
    output prio_t             prio_o [NUM_SRC]
);
    logic [15:0] addr_ext;
    assign addr_ext = 16'(addr_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sw_bits_o <= '0;
        end else if (wr_i && addr_hit(addr_ext, ADR_SWSET)) begin
            sw_bits_o <= sw_bits_o | sw_data_i;
        end else if (wr_i && addr_hit(addr_ext, ADR_SWCLR)) begin
            sw_bits_o <= sw_bits_o & ~sw_data_i;
        end
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_prio
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                prio_o[g] <= '0;
            end else if (wr_i && addr_hit(addr_ext, ADR_PRIO_BASE + g)) begin
                prio_o[g] <= prio_data_i;
            end
        end
    end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
    import pic_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [NUM_SRC-1:0] pend_i,
    input  prio_t              prio_i [NUM_SRC],
    input  prio_t              ceil_i,
    output winner_t            win_q_o
);
    winner_t best;

    // Ascending scan with a strict compare: on a tie the earlier index stays.
    always_comb begin
        best = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend_i[i] && (prio_i[i] > ceil_i) &&
                (!best.valid || (prio_i[i] > best.prio))) begin
                best.valid = 1'b1;
                best.vec   = VEC_W'(i);
                best.prio  = prio_i[i];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) win_q_o <= '0;
        else       win_q_o <= best;
    end
endmodule

// File: rtl/pic_ceil_stack.sv
module pic_ceil_stack
    import pic_pkg::*;
#(
    parameter int STACK_DEPTH = 16,
    localparam int DEPTH_W    = $clog2(STACK_DEPTH)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  ceil_op_e         op_i,
    input  prio_t            val_i,
    output prio_t            ceil_o,
    output logic [DEPTH_W:0] depth_o
);
    prio_t stk_q [STACK_DEPTH];
    logic  full;
    assign full = depth_o >= (DEPTH_W+1)'(STACK_DEPTH);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ceil_o  <= '0;
            depth_o <= '0;
        end else begin
            unique case (op_i)
                CEIL_LOAD: ceil_o <= val_i;
                CEIL_PUSH: begin
                    if (!full) begin
                        stk_q[DEPTH_W'(depth_o)] <= ceil_o;
                        depth_o <= depth_o + 1'b1;
                    end
                    ceil_o <= val_i;
                end
                CEIL_POP: begin
                    if (depth_o != '0) begin
                        ceil_o  <= stk_q[DEPTH_W'(depth_o - 1'b1)];
                        depth_o <= depth_o - 1'b1;
                    end else begin
                        ceil_o <= '0;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
    import pic_pkg::*;
#(
    parameter int NUM_HW      = 24,
    parameter int NUM_SW      = 8,
    parameter int STACK_DEPTH = 16,
    parameter int ADDR_W      = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [NUM_HW-1:0] hw_req_i,
    input  logic              bus_valid_i,
    input  logic              bus_write_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              bus_rvalid_o,
    output logic              irq_o,
    output logic [8:0]        irq_vec_o
);
    localparam int NUM_SRC = NUM_HW + NUM_SW;
    localparam int DEPTH_W = $clog2(STACK_DEPTH);
    localparam int WD_USED = (NUM_SW > PRIO_W) ? NUM_SW : PRIO_W;

    logic               wr, rd;
    logic [15:0]        addr_ext;
    logic [NUM_SW-1:0]  sw_bits;
    prio_t              prio [NUM_SRC];
    logic [NUM_SRC-1:0] pend;
    prio_t              ceil_q;
    logic [DEPTH_W:0]   depth_q;
    winner_t            win_q;
    ceil_op_e           ceil_op;
    prio_t              ceil_val;
    logic [31:0]        rd_mux;
    logic               unused_wdata;

    assign wr           = bus_valid_i && bus_write_i;
    assign rd           = bus_valid_i && !bus_write_i;
    assign addr_ext     = 16'(bus_addr_i);
    assign unused_wdata = ^bus_wdata_i[31:WD_USED];

    pic_cfg_regs #(.NUM_SW(NUM_SW), .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .wr_i        (wr),
        .addr_i      (bus_addr_i),
        .sw_data_i   (bus_wdata_i[NUM_SW-1:0]),
        .prio_data_i (bus_wdata_i[PRIO_W-1:0]),
        .sw_bits_o   (sw_bits),
        .prio_o      (prio)
    );

    assign pend = {hw_req_i, sw_bits};

    pic_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .pend_i  (pend),
        .prio_i  (prio),
        .ceil_i  (ceil_q),
        .win_q_o (win_q)
    );

    always_comb begin
        ceil_op  = CEIL_HOLD;
        ceil_val = bus_wdata_i[PRIO_W-1:0];
        if (rd && addr_hit(addr_ext, ADR_ACK) && win_q.valid) begin
            ceil_op  = CEIL_PUSH;
            ceil_val = win_q.prio;
        end else if (wr && addr_hit(addr_ext, ADR_EOS)) begin
            ceil_op = CEIL_POP;
        end else if (wr && addr_hit(addr_ext, ADR_CEIL)) begin
            ceil_op = CEIL_LOAD;
        end
    end

    pic_ceil_stack #(.STACK_DEPTH(STACK_DEPTH)) u_stack (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .op_i    (ceil_op),
        .val_i   (ceil_val),
        .ceil_o  (ceil_q),
        .depth_o (depth_q)
    );

    always_comb begin
        rd_mux = '0;
        if (addr_hit(addr_ext, ADR_CEIL)) begin
            rd_mux = 32'(ceil_q);
        end else if (addr_hit(addr_ext, ADR_ACK)) begin
            rd_mux = win_q.valid ? 32'(win_q.vec) : 32'(SPURIOUS_VEC);
        end else if (addr_hit(addr_ext, ADR_SWSET)) begin
            rd_mux = 32'(sw_bits);
        end else begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (addr_hit(addr_ext, ADR_PRIO_BASE + i)) rd_mux = 32'(prio[i]);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            bus_rdata_o  <= '0;
            bus_rvalid_o <= 1'b0;
        end else begin
            bus_rvalid_o <= rd;
            if (rd) bus_rdata_o <= rd_mux;
        end
    end

    assign irq_o     = win_q.valid;
    assign irq_vec_o = win_q.vec;
endmodule

// File: rtl/pic_ctrl_chk.sv
module pic_ctrl_chk
    import pic_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DEPTH_W = 4
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              bus_valid_i,
    input logic              bus_write_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [31:0]       bus_rdata_o,
    input logic              irq_o,
    input prio_t             irq_prio,
    input prio_t             ceil_q,
    input logic [DEPTH_W:0]  depth_q
);
    logic ack_rd, eos_wr;
    assign ack_rd = bus_valid_i && !bus_write_i && (bus_addr_i == ADDR_W'(ADR_ACK));
    assign eos_wr = bus_valid_i && bus_write_i && (bus_addr_i == ADDR_W'(ADR_EOS));

    assert_reset_quiet_R1: assert property (@(posedge clk_i)
        rst_i |=> (!irq_o && ceil_q == '0 && depth_q == '0));

    assert_zero_prio_silent_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> (irq_prio != '0));

    assert_above_ceiling_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> (irq_prio > $past(ceil_q)));

    assert_ack_loads_ceiling_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (ack_rd && irq_o) |=> (ceil_q == $past(irq_prio)));

    assert_empty_pop_zero_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (eos_wr && depth_q == '0) |=> (ceil_q == '0));

    assert_spurious_ack_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        (ack_rd && !irq_o) |=> (bus_rdata_o[8:0] == 9'h1FF && $stable(ceil_q) && $stable(depth_q)));
endmodule

bind pic_ctrl pic_ctrl_chk #(.ADDR_W(ADDR_W), .DEPTH_W(DEPTH_W)) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .bus_valid_i (bus_valid_i),
    .bus_write_i (bus_write_i),
    .bus_addr_i  (bus_addr_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o),
    .irq_prio    (win_q.prio),
    .ceil_q      (ceil_q),
    .depth_q     (depth_q)
);

// File: tb/pic_ctrl_tb.sv
module pic_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_HW = 24;
    localparam int NUM_SW = 8;
    localparam int A_CEIL = 'h00, A_ACK = 'h01, A_EOS = 'h02, A_SET = 'h03, A_CLR = 'h04, A_PRIO = 'h40;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NUM_HW-1:0] hw_req = '0;
    logic              bv = 1'b0, bw = 1'b0;
    logic [7:0]        ba = '0;
    logic [31:0]       bwd = '0;
    logic [31:0]       brd;
    logic              brv, irq;
    logic [8:0]        ivec;

    int n_run = 0, n_fail = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pic_ctrl #(.NUM_HW(NUM_HW), .NUM_SW(NUM_SW)) u_dut (
        .clk_i(clk), .rst_i(rst), .hw_req_i(hw_req),
        .bus_valid_i(bv), .bus_write_i(bw), .bus_addr_i(ba), .bus_wdata_i(bwd),
        .bus_rdata_o(brd), .bus_rvalid_o(brv), .irq_o(irq), .irq_vec_o(ivec)
    );

    typedef struct packed {
        logic [5:0] sa; logic [3:0] pa;
        logic [5:0] sb; logic [3:0] pb;
        logic [3:0] ceil;
        logic       exp_irq;
        logic [8:0] exp_vec;
        logic [3:0] req;
    } row_t;

    localparam row_t TBL [8] = '{
        '{6'd10, 4'd5, 6'd3,  4'd7,  4'd0,  1'b1, 9'd3,  4'd5},  // R5 software beats peripheral
        '{6'd12, 4'd6, 6'd20, 4'd6,  4'd0,  1'b1, 9'd12, 4'd6},  // R6 tie between lines
        '{6'd2,  4'd6, 6'd1,  4'd6,  4'd0,  1'b1, 9'd1,  4'd6},  // R6 tie between soft bits
        '{6'd9,  4'd4, 6'd15, 4'd0,  4'd4,  1'b0, 9'd0,  4'd7},  // R7 equal to ceiling blocks
        '{6'd9,  4'd5, 6'd15, 4'd0,  4'd4,  1'b1, 9'd9,  4'd7},  // R7 above ceiling passes
        '{6'd5,  4'd0, 6'd30, 4'd0,  4'd0,  1'b0, 9'd0,  4'd4},  // R4 zero priority silent
        '{6'd31, 4'd15,6'd0,  4'd14, 4'd14, 1'b1, 9'd31, 4'd7},  // R7 top level over high ceiling
        '{6'd7,  4'd1, 6'd8,  4'd2,  4'd0,  1'b1, 9'd8,  4'd2}   // R2 first line is vector NUM_SW
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input int a, input logic [31:0] d);
        bv = 1'b1; bw = 1'b1; ba = 8'(a); bwd = d;
        @(negedge clk);
        bv = 1'b0; bw = 1'b0;
    endtask

    task automatic bus_rd(input int a, output logic [31:0] d);
        bv = 1'b1; bw = 1'b0; ba = 8'(a);
        @(negedge clk);
        bv = 1'b0;
        d = brd;
    endtask

    task automatic set_src(input int idx, input logic on);
        if (idx < NUM_SW) bus_wr(on ? A_SET : A_CLR, 32'(1) << idx);
        else              hw_req[idx-NUM_SW] = on;
    endtask

    task automatic settle();
        @(negedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(1, 32'(irq), 0);
        bus_rd(A_CEIL, r);     check(1, r, 0);
        bus_rd(A_SET, r);      check(1, r, 0);
        bus_rd(A_PRIO + 5, r); check(1, r, 0);

        // R10 spurious acknowledge
        bus_rd(A_ACK, r);  check(10, r, 32'h1FF);
        bus_rd(A_CEIL, r); check(10, r, 0);

        // R3 software set and clear
        bus_wr(A_SET, 32'h81); bus_rd(A_SET, r); check(3, r, 32'h81);
        bus_wr(A_CLR, 32'h01); bus_rd(A_SET, r); check(3, r, 32'h80);
        bus_wr(A_CLR, 32'hFF); bus_rd(A_SET, r); check(3, r, 0);

        // Table walk: R2 R4 R5 R6 R7 R8
        foreach (TBL[k]) begin
            bus_wr(A_PRIO + int'(TBL[k].sa), 32'(TBL[k].pa));
            bus_wr(A_PRIO + int'(TBL[k].sb), 32'(TBL[k].pb));
            bus_wr(A_CEIL, 32'(TBL[k].ceil));
            set_src(int'(TBL[k].sa), 1'b1);
            set_src(int'(TBL[k].sb), 1'b1);
            settle();
            check(int'(TBL[k].req), 32'(irq), 32'(TBL[k].exp_irq));
            if (TBL[k].exp_irq) begin
                check(2, 32'(ivec), 32'(TBL[k].exp_vec));
                bus_rd(A_ACK, r); check(8, r, 32'(TBL[k].exp_vec));
                bus_rd(A_CEIL, r);
                check(8, r, 32'((TBL[k].exp_vec == 9'(TBL[k].sa)) ? TBL[k].pa : TBL[k].pb));
                bus_wr(A_EOS, 0);
                bus_rd(A_CEIL, r); check(9, r, 32'(TBL[k].ceil));
            end
            set_src(int'(TBL[k].sa), 1'b0);
            set_src(int'(TBL[k].sb), 1'b0);
            bus_wr(A_PRIO + int'(TBL[k].sa), 0);
            bus_wr(A_PRIO + int'(TBL[k].sb), 0);
            bus_wr(A_CEIL, 0);
            settle();
        end

        // R11 registered output timing, R12 level pending across acknowledge
        bus_wr(A_PRIO + 11, 11);
        hw_req[3] = 1'b1;
        #1 check(11, 32'(irq), 0);
        @(negedge clk);
        check(11, 32'(irq), 1);
        check(11, 32'(ivec), 11);
        bus_rd(A_ACK, r); check(8, r, 11);
        @(negedge clk);
        check(7, 32'(irq), 0);
        bus_wr(A_EOS, 0);
        @(negedge clk);
        check(12, 32'(irq), 1);
        hw_req[3] = 1'b0;
        @(negedge clk);
        check(12, 32'(irq), 0);

        // R9 nesting then empty pop
        bus_wr(A_PRIO + 9, 3);
        hw_req[1] = 1'b1;
        settle();
        bus_rd(A_ACK, r);  check(8, r, 9);
        bus_wr(A_PRIO + 4, 8);
        bus_wr(A_SET, 32'h10);
        settle();
        check(5, 32'(ivec), 4);
        bus_rd(A_ACK, r);  check(8, r, 4);
        bus_rd(A_CEIL, r); check(8, r, 8);
        bus_wr(A_EOS, 0); bus_rd(A_CEIL, r); check(9, r, 3);
        bus_wr(A_EOS, 0); bus_rd(A_CEIL, r); check(9, r, 0);
        bus_wr(A_CLR, 32'h10); hw_req[1] = 1'b0;
        settle();
        bus_wr(A_EOS, 0); bus_rd(A_CEIL, r); check(9, r, 0);

        // Same-cycle: acknowledge while the winning line drops (R8, R12)
        bus_wr(A_PRIO + 10, 9);
        hw_req[2] = 1'b1;
        settle();
        check(12, 32'(irq), 1);
        bv = 1'b1; bw = 1'b0; ba = 8'(A_ACK); hw_req[2] = 1'b0;
        @(negedge clk);
        bv = 1'b0;
        check(8, brd, 10);
        check(12, 32'(irq), 0);
        bus_rd(A_CEIL, r); check(8, r, 9);
        bus_wr(A_EOS, 0);  bus_rd(A_CEIL, r); check(9, r, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule